// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block shifts or rotates a byte, word or long operand by a count from 0 to 63 in one combinational pass. It also produces the five condition flags that such an operation defines: extend (X), negative (N), zero (Z), overflow (V) and carry (C). The result is available in the same cycle as the inputs. The flags are captured in a register on the clock edge where the load strobe is high.

There are four modes: arithmetic shift, logical shift, plain rotate, and rotate through extend. The last mode treats the current X flag as one extra bit above the operand, so the rotation is one bit wider than the operand size. The caller supplies the current X on its own input. It normally wires that input back from the block's X output, which lets back-to-back multiprecision rotates chain through the flag.

Top module: `shift_rotate_unit`

## Requirements
- R1: Logical shifts fill vacated positions with zero. A count equal to or larger than the operand width gives a zero result.
- R2: An arithmetic right shift copies the sign bit into vacated positions. An arithmetic left shift gives the same result as a logical left shift.
- R3: A plain rotate moves bits circularly within the operand width, so the count acts modulo that width.
- R4: Rotate through extend rotates the (width+1)-bit value formed by X above the operand. The new X is the top bit of that rotated value, and the result is its low bits.
- R5: For a nonzero count, C is the last bit moved out of the operand. For arithmetic shifts, logical shifts and rotate through extend, the new X equals that bit.
- R6: With a zero count, arithmetic shifts, logical shifts and plain rotates clear C and keep X equal to the supplied X input.
- R7: With a zero count, rotate through extend leaves the result unchanged and sets C and the new X both equal to the supplied X input.
- R8: A plain rotate always loads X from the supplied X input, whatever the count.
- R9: V is set only by an arithmetic left shift, and only when the most significant bit took more than one value during the bit-by-bit shift. All other operations clear V.
- R10: N is the most significant bit of the sized result. Z is set exactly when the sized result is zero.
- R11: Reset clears all five flags. The flags change only on a rising clock edge with the load strobe high, and hold their value otherwise.
- R12: Size code 0 selects a byte, 1 a word, and 2 or 3 a long. Operand bits above the selected size are ignored, and result bits above it read zero.
- R13: Mode code 0 is arithmetic shift, 1 is logical shift, 2 is plain rotate and 3 is rotate through extend. The direction input is 1 for left and 0 for right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| flagLoad | input | 1 | Capture the new flags on this clock edge |
| operand | input | 32 | Value to shift or rotate |
| count | input | 6 | Shift or rotate distance, 0 to 63 |
| shiftLeft | input | 1 | 1 for left, 0 for right |
| mode | input | 2 | Operation code per R13 |
| opSize | input | 2 | Operand size code per R12 |
| xIn | input | 1 | Current extend flag |
| result | output | 32 | Shifted or rotated value, zero above the size |
| xFlag | output | 1 | Registered extend flag |
| nFlag | output | 1 | Registered negative flag |
| zFlag | output | 1 | Registered zero flag |
| vFlag | output | 1 | Registered overflow flag |
| cFlag | output | 1 | Registered carry flag |

## Verification
Two functions can land in the same cycle: the flag register capturing a new X, and the datapath reading X as an extra rotation bit. When xIn is wired back from xFlag, both act on the edge. The bench provokes this with 33 chained single-bit long rotates through extend, each fed with the previous result and the registered X. It then judges that the operand and X have returned exactly to their starting values. Around this, a sweep compares every count, mode, direction and size against a bit-serial model, and a held-load step confirms that the flags stay put while the inputs change.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;

  localparam int NUM_SIZES = 3;

  typedef enum logic [1:0] {
    MODE_ASHIFT = 2'd0,
    MODE_LSHIFT = 2'd1,
    MODE_ROT    = 2'd2,
    MODE_ROTX   = 2'd3
  } shiftModeE;

  typedef struct packed {
    logic                 toLeft;
    logic                 isArith;
    logic                 isLogic;
    logic                 isRot;
    logic                 isRotX;
    logic [NUM_SIZES-1:0] laneSel;
  } ctrlStrobesT;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } flagSetT;

endpackage

// File: rtl/shift_lane.sv
module shift_lane
  import shift_rotate_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input  logic [W-1:0]     opIn,
  input  logic [CNT_W-1:0] cnt,
  input  ctrlStrobesT      str,
  input  logic             xIn,
  output logic [W-1:0]     resOut,
  output flagSetT          flagsOut
);

  localparam int SPAN = 1 << CNT_W;
  localparam int EXT  = W + SPAN;

  int             cntI;
  int             rotK;
  int             rxK;
  logic [EXT-1:0] leftExt;
  logic [EXT-1:0] zeroExt;
  logic [EXT-1:0] signExt;
  logic [EXT-1:0] rzShift;
  logic [EXT-1:0] rsShift;
  logic [2*W-1:0] rotDbl;
  logic [2*W-1:0] rotLeftAll;
  logic [2*W-1:0] rotRightAll;
  logic [2*W+1:0] rxDbl;
  logic [2*W+1:0] rxLeftAll;
  logic [2*W+1:0] rxRightAll;
  logic [W-1:0]   rotRes;
  logic [W:0]     rxRes;
  logic [W-1:0]   topMask;
  logic [W-1:0]   topBits;
  logic           signFlip;
  logic           lastOut;
  logic [W-1:0]   res;

  // shifts through a zero- or sign-extended window wide enough for any count
  always_comb begin
    cntI    = int'(cnt);
    leftExt = {{SPAN{1'b0}}, opIn} << cntI;
    zeroExt = {{SPAN{1'b0}}, opIn};
    signExt = {{SPAN{opIn[W-1]}}, opIn};
    rzShift = zeroExt >> cntI;
    rsShift = $signed(signExt) >>> cntI;
  end

  // rotates: doubled operand, count reduced modulo the ring length
  always_comb begin
    rotK        = cntI % W;
    rxK         = cntI % (W + 1);
    rotDbl      = {opIn, opIn};
    rotLeftAll  = rotDbl << rotK;
    rotRightAll = rotDbl >> rotK;
    rotRes      = str.toLeft ? rotLeftAll[2*W-1:W] : rotRightAll[W-1:0];
    rxDbl       = {xIn, opIn, xIn, opIn};
    rxLeftAll   = rxDbl << rxK;
    rxRightAll  = rxDbl >> rxK;
    rxRes       = str.toLeft ? rxLeftAll[2*W+1:W+1] : rxRightAll[W:0];
  end

  // sign change during a left shift: the top cnt+1 bits are not all equal,
  // or a zero has reached the top while some operand bit was set
  always_comb begin
    topMask  = ~({W{1'b1}} >> (cntI + 1));
    topBits  = opIn & topMask;
    signFlip = (topBits != '0) && ((topBits != topMask) || (cntI >= W));
  end

  always_comb begin
    res     = opIn;
    lastOut = 1'b0;
    flagsOut = '0;
    if (str.isRotX) begin
      res        = rxRes[W-1:0];
      flagsOut.c = rxRes[W];
      flagsOut.x = rxRes[W];
    end else if (str.isRot) begin
      res        = rotRes;
      flagsOut.c = (cntI == 0) ? 1'b0 : (str.toLeft ? rotRes[0] : rotRes[W-1]);
      flagsOut.x = xIn;
    end else begin
      if (str.toLeft) begin
        res     = leftExt[W-1:0];
        lastOut = leftExt[W];
      end else if (str.isArith) begin
        res     = rsShift[W-1:0];
        lastOut = (cntI == 0) ? 1'b0 : signExt[cntI-1];
      end else begin
        res     = rzShift[W-1:0];
        lastOut = (cntI == 0) ? 1'b0 : zeroExt[cntI-1];
      end
      flagsOut.c = (cntI == 0) ? 1'b0 : lastOut;
      flagsOut.x = (cntI == 0) ? xIn : lastOut;
      flagsOut.v = str.isArith && str.toLeft && signFlip;
    end
    flagsOut.n = res[W-1];
    flagsOut.z = (res == '0);
    resOut     = res;
  end

endmodule

// File: rtl/shift_rotate_dp.sv
module shift_rotate_dp
  import shift_rotate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  ctrlStrobesT       strobes,
  input  logic              xIn,
  output logic [DATA_W-1:0] result,
  output flagSetT           nextFlags
);

  logic [DATA_W-1:0] laneRes   [NUM_SIZES];
  flagSetT           laneFlags [NUM_SIZES];

  for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_lane
    localparam int LW = 8 << gi;
    logic [LW-1:0] narrow;

    shift_lane #(
      .W     (LW),
      .CNT_W (CNT_W)
    ) lane_i (
      .opIn     (operand[LW-1:0]),
      .cnt      (count),
      .str      (strobes),
      .xIn      (xIn),
      .resOut   (narrow),
      .flagsOut (laneFlags[gi])
    );

    assign laneRes[gi] = DATA_W'(narrow);
  end

  always_comb begin
    result    = '0;
    nextFlags = '0;
    for (int i = 0; i < NUM_SIZES; i++) begin
      if (strobes.laneSel[i]) begin
        result    = laneRes[i];
        nextFlags = laneFlags[i];
      end
    end
  end

endmodule

// File: rtl/shift_rotate_ctrl.sv
module shift_rotate_ctrl
  import shift_rotate_pkg::*;
#(
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flagLoad,
  input  logic [1:0]        mode,
  input  logic              shiftLeft,
  input  logic [SIZE_W-1:0] opSize,
  input  flagSetT           nextFlags,
  output ctrlStrobesT       strobes,
  output flagSetT           flagsQ
);

  shiftModeE            modeE;
  logic [NUM_SIZES-1:0] laneSelW;

  assign modeE = shiftModeE'(mode);

  // the widest lane also takes every size code beyond the last one
  for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_sel
    if (gi == NUM_SIZES - 1) begin : g_top
      assign laneSelW[gi] = (int'(opSize) >= gi);
    end else begin : g_low
      assign laneSelW[gi] = (int'(opSize) == gi);
    end
  end

  always_comb begin
    strobes.toLeft  = shiftLeft;
    strobes.isArith = (modeE == MODE_ASHIFT);
    strobes.isLogic = (modeE == MODE_LSHIFT);
    strobes.isRot   = (modeE == MODE_ROT);
    strobes.isRotX  = (modeE == MODE_ROTX);
    strobes.laneSel = laneSelW;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else if (flagLoad) begin
      flagsQ <= nextFlags;
    end
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_rotate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flagLoad,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic              shiftLeft,
  input  logic [1:0]        mode,
  input  logic [SIZE_W-1:0] opSize,
  input  logic              xIn,
  output logic [DATA_W-1:0] result,
  output logic              xFlag,
  output logic              nFlag,
  output logic              zFlag,
  output logic              vFlag,
  output logic              cFlag
);

  ctrlStrobesT strobes;
  flagSetT     nextFlags;
  flagSetT     flagsQ;

  shift_rotate_ctrl #(
    .SIZE_W (SIZE_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .flagLoad  (flagLoad),
    .mode      (mode),
    .shiftLeft (shiftLeft),
    .opSize    (opSize),
    .nextFlags (nextFlags),
    .strobes   (strobes),
    .flagsQ    (flagsQ)
  );

  shift_rotate_dp #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) dp_i (
    .operand   (operand),
    .count     (count),
    .strobes   (strobes),
    .xIn       (xIn),
    .result    (result),
    .nextFlags (nextFlags)
  );

  assign xFlag = flagsQ.x;
  assign nFlag = flagsQ.n;
  assign zFlag = flagsQ.z;
  assign vFlag = flagsQ.v;
  assign cFlag = flagsQ.c;

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk
  import shift_rotate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int SIZE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              flagLoad,
  input logic [DATA_W-1:0] operand,
  input logic [CNT_W-1:0]  count,
  input logic              shiftLeft,
  input logic [1:0]        mode,
  input logic [SIZE_W-1:0] opSize,
  input logic              xIn,
  input logic [DATA_W-1:0] result,
  input logic              xFlag,
  input logic              nFlag,
  input logic              zFlag,
  input logic              vFlag,
  input logic              cFlag
);

  logic szMsb;
  logic szZero;
  logic upperClear;

  always_comb begin
    case (opSize)
      2'd0: begin
        szMsb      = result[7];
        szZero     = (result[7:0] == '0);
        upperClear = (result[DATA_W-1:8] == '0);
      end
      2'd1: begin
        szMsb      = result[15];
        szZero     = (result[15:0] == '0);
        upperClear = (result[DATA_W-1:16] == '0);
      end
      default: begin
        szMsb      = result[DATA_W-1];
        szZero     = (result == '0);
        upperClear = 1'b1;
      end
    endcase
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !flagLoad |=> $stable({xFlag, nFlag, zFlag, vFlag, cFlag}));

  p_v_only_asl_r9: assert property (@(posedge clk) disable iff (!rstN)
    flagLoad && !(mode == MODE_ASHIFT && shiftLeft) |=> !vFlag);

  p_zero_cnt_r6: assert property (@(posedge clk) disable iff (!rstN)
    flagLoad && count == '0 && mode != MODE_ROTX |=> !cFlag && xFlag == $past(xIn));

  p_zero_cnt_rotx_r7: assert property (@(posedge clk) disable iff (!rstN)
    flagLoad && count == '0 && mode == MODE_ROTX |=> cFlag == $past(xIn) && xFlag == $past(xIn));

  p_rot_keeps_x_r8: assert property (@(posedge clk) disable iff (!rstN)
    flagLoad && mode == MODE_ROT |=> xFlag == $past(xIn));

  p_x_tracks_c_r5: assert property (@(posedge clk) disable iff (!rstN)
    flagLoad && count != '0 && mode != MODE_ROT |=> xFlag == cFlag);

  p_nz_from_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagLoad |=> nFlag == $past(szMsb) && zFlag == $past(szZero));

  p_upper_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    upperClear);

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .SIZE_W (SIZE_W)
) chk_i (.*);

// File: tb/shift_rotate_unit_tb_top.sv
`timescale 1ns/1ps
module shift_rotate_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flagLoad = 1'b0;
  logic [31:0] operand = '0;
  logic [5:0]  count = '0;
  logic        shiftLeft = 1'b0;
  logic [1:0]  mode = '0;
  logic [1:0]  opSize = '0;
  logic        xIn = 1'b0;
  logic [31:0] result;
  logic        xFlag, nFlag, zFlag, vFlag, cFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shift_rotate_unit dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .flagLoad  (flagLoad),
    .operand   (operand),
    .count     (count),
    .shiftLeft (shiftLeft),
    .mode      (mode),
    .opSize    (opSize),
    .xIn       (xIn),
    .result    (result),
    .xFlag     (xFlag),
    .nFlag     (nFlag),
    .zFlag     (zFlag),
    .vFlag     (vFlag),
    .cFlag     (cFlag)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (size %0d mode %0d left %0d cnt %0d op %h x %0d)",
               tag, what, act, exp, opSize, mode, shiftLeft, count, operand, xIn);
    end
  endtask

  // bit-serial reference: one position per step
  task automatic refModel(input logic [31:0] op, input int sz, input int md, input bit lf,
                          input int cn, input bit xi, output logic [31:0] r,
                          output bit ex, output bit en, output bit ez, output bit ev, output bit ec);
    int w;
    logic [31:0] mask;
    logic [31:0] val;
    bit msb0, out, sgn, xs, cs, vs;
    w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = 32'((64'd1 << w) - 64'd1);
    val  = op & mask;
    msb0 = val[w-1];
    xs = xi; cs = 1'b0; vs = 1'b0;
    for (int i = 0; i < cn; i++) begin
      if (lf) begin
        out = val[w-1];
        case (md)
          2:       val = ((val << 1) | {31'b0, out}) & mask;
          3:       val = ((val << 1) | {31'b0, xs}) & mask;
          default: val = (val << 1) & mask;
        endcase
      end else begin
        out = val[0];
        sgn = val[w-1];
        case (md)
          0:       val = (val >> 1) | ({31'b0, sgn} << (w - 1));
          2:       val = (val >> 1) | ({31'b0, out} << (w - 1));
          3:       val = (val >> 1) | ({31'b0, xs} << (w - 1));
          default: val = val >> 1;
        endcase
      end
      if (md == 0 && lf && val[w-1] != msb0) vs = 1'b1;
      cs = out;
      if (md != 2) xs = out;
    end
    if (cn == 0 && md == 3) cs = xi;
    r = val; ex = xs; en = val[w-1]; ez = (val == 0); ev = vs; ec = cs;
  endtask

  task automatic runVec(input logic [31:0] op, input int sz, input int md, input bit lf,
                        input int cn, input bit xi);
    logic [31:0] er;
    bit ex, en, ez, ev, ec;
    string rTag, cTag, xTag;
    @(negedge clk);
    operand = op; opSize = 2'(sz); mode = 2'(md); shiftLeft = lf; count = 6'(cn); xIn = xi;
    flagLoad = 1'b1;
    refModel(op, sz, md, lf, cn, xi, er, ex, en, ez, ev, ec);
    rTag = (md == 0) ? "R2" : (md == 1) ? "R1" : (md == 2) ? "R3" : "R4";
    cTag = (cn != 0) ? "R5" : (md == 3) ? "R7" : "R6";
    xTag = (md == 2) ? "R8" : cTag;
    #1;
    chk(result == er, rTag, "result", result, er);
    if (sz < 2) chk(result >> (8 << sz) == 0, "R12", "upper bits", result, er);
    @(posedge clk);
    #1;
    chk(cFlag == ec, cTag, "C", {31'b0, cFlag}, {31'b0, ec});
    chk(xFlag == ex, xTag, "X", {31'b0, xFlag}, {31'b0, ex});
    chk(vFlag == ev, "R9", "V", {31'b0, vFlag}, {31'b0, ev});
    chk(nFlag == en && zFlag == ez, "R10", "NZ", {30'b0, nFlag, zFlag}, {30'b0, en, ez});
  endtask

  initial begin
    repeat (5000 * 40) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [5];
    logic [31:0] curOp;
    bit curX;
    bit px, pn, pz, pv, pc;
    pats[0] = 32'h0000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h0000_0001;
    pats[3] = 32'h9E37_79B9;
    pats[4] = 32'h0000_0000;

    repeat (3) @(posedge clk);
    #1;
    chk({xFlag, nFlag, zFlag, vFlag, cFlag} == 5'b0, "R11", "reset flags",
        {27'b0, xFlag, nFlag, zFlag, vFlag, cFlag}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // sweep: R13 codes, every count at every size
    for (int sz = 0; sz < 4; sz++) begin
      pats[4] = 32'h5A00_0000 | (32'h1 << ((sz == 0) ? 7 : (sz == 1) ? 15 : 31));
      for (int md = 0; md < 4; md++) begin
        for (int lf = 0; lf < 2; lf++) begin
          for (int cn = 0; cn < 64; cn++) begin
            for (int p = 0; p < 5; p++) begin
              runVec(pats[p], sz, md, lf[0], cn, (p % 2) == 1);
              if (sz == 3) break;
            end
          end
        end
      end
    end

    // R11: flags hold while the load strobe is low
    runVec(32'h0000_0081, 0, 0, 1'b1, 1, 1'b0);
    px = xFlag; pn = nFlag; pz = zFlag; pv = vFlag; pc = cFlag;
    @(negedge clk);
    flagLoad = 1'b0; operand = 32'h0; mode = 2'd3; count = 6'd0; xIn = 1'b0; shiftLeft = 1'b0;
    @(posedge clk);
    #1;
    chk({xFlag, nFlag, zFlag, vFlag, cFlag} == {px, pn, pz, pv, pc}, "R11", "hold flags",
        {27'b0, xFlag, nFlag, zFlag, vFlag, cFlag}, {27'b0, px, pn, pz, pv, pc});

    // R4: chained rotate through extend, X fed back from the flag register
    runVec(32'h0, 2, 1, 1'b0, 0, 1'b1);
    curOp = 32'h1234_5678;
    curX  = xFlag;
    for (int step = 0; step < 33; step++) begin
      @(negedge clk);
      flagLoad = 1'b1; opSize = 2'd2; mode = 2'd3; shiftLeft = 1'b1; count = 6'd1;
      operand = curOp; xIn = xFlag;
      #1;
      curOp = result;
      @(posedge clk);
      #1;
      if (step == 0) chk(xFlag == 1'b0 && curOp == 32'h2468_ACF1, "R4", "chain step 1",
                         curOp, 32'h2468_ACF1);
    end
    chk(curOp == 32'h1234_5678 && xFlag == curX, "R4", "chain 33 steps",
        {curOp[30:0], xFlag}, {31'h1234_5678, curX});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule